// File: doc/BRIEF.md
# Multi-Display Character Write Interface

This block turns a single character write request into a correctly timed write to one of up to sixteen four-character display modules. The modules share a 7-bit character bus and a 2-bit digit address, but none of them has a chip enable. The block therefore gives every module its own active-low write strobe. Each strobe is decoded from the upper bits of a 6-bit character address and is gated by both a bank-select input and the internal write pulse.

A request arrives on a valid/ready port. It carries the character address and the character code. Once accepted, the block holds the bus for one setup cycle. It then holds the chosen strobe low for a parameterised number of cycles, and it keeps the bus steady for one more cycle after the strobe rises. Back-pressure is plain. `req_ready` is low for the whole sequence. A request is taken only on an edge where `req_valid` and `req_ready` are both high. While `req_ready` is low the request inputs have no effect, and the requester may change or withdraw them freely.

A parameter sets the capacity to 16, 32 or 64 characters. Addresses beyond the configured capacity never produce a strobe. A shadow copy of all display latches, indexed by the 6-bit character address, mirrors what each module has latched. It can be read combinationally.

Top module: `disp_wr_if`

## Requirements
- R1: After reset, `busy` is 0, `req_ready` is 1, all sixteen strobes are high, `disp_data` and `disp_digit` are 0, and every shadow entry reads 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is the inverse of `busy`. While busy, requests are not accepted and change no output.
- R3: In the first cycle after acceptance, `disp_data` carries the request code and `disp_digit` carries address bits [1:0]. All strobes stay high in that cycle.
- R4: Strobe bit `disp_wr_n[k]`, where k is address bits [5:2], is low from the 2nd through the (PULSE_CYC+1)th cycle after acceptance, as long as `bank_sel` is 1.
- R5: For one cycle after the strobe window, `busy` stays high and the bus stays unchanged. `busy` is high for exactly PULSE_CYC+2 cycles per request, and the bus is stable throughout.
- R6: At most one strobe bit is low in any cycle.
- R7: A strobe is low only while `bank_sel` is 1. In a cycle where `bank_sel` is 0, no strobe is low and no shadow entry changes.
- R8: A request whose address is CHARS or more never drives a strobe low. Strobe bits CHARS/4 and above stay high permanently.
- R9: On every rising edge where a module's strobe is low, the shadow entry at the latched character address takes the latched code. All other entries keep their values.
- R10: `rd_data` shows the shadow entry selected by `rd_addr` in the same cycle, without any register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 6 | Character address: [5:2] module, [1:0] digit |
| req_data | input | 7 | Character code |
| bank_sel | input | 1 | Bank select, gates every strobe |
| busy | output | 1 | Write sequence in progress |
| disp_data | output | 7 | Shared character bus to the modules |
| disp_digit | output | 2 | Shared digit address to the modules |
| disp_wr_n | output | 16 | Per-module write strobes, active low |
| rd_addr | input | 6 | Shadow read address |
| rd_data | output | 7 | Shadow read data |

## Verification
Take the accepting edge as edge 0. `busy` rises just after edge 0 and falls just after edge PULSE_CYC+2. The bus changes only at edge 0. The strobe falls after edge 1 and rises after edge PULSE_CYC+1. A shadow entry changes at each edge inside that strobe window and appears on `rd_data` right after that edge. The bench keeps a behavioural model that steps on the same rising edges. It compares every output 1 ns after each falling edge. At that point both the registered state and the combinational gating by `bank_sel` and `rd_addr` have settled, so each result is checked in the exact cycle it is due.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 7;
  localparam int DIG_W   = 2;
  localparam int MOD_W   = ADDR_W - DIG_W;
  localparam int MAX_MOD = 1 << MOD_W;
  localparam int DEPTH   = 1 << ADDR_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD
  } seq_st_t;
endpackage

// File: rtl/disp_seq.sv
module disp_seq
  import disp_pkg::*;
#(
  parameter int PULSE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  output logic              busy,
  output logic              pulse,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);
  localparam int CW = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

  seq_st_t       st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          st     <= ST_SETUP;
          addr_q <= req_addr;
          data_q <= req_data;
        end
        ST_SETUP: begin
          st  <= ST_PULSE;
          cnt <= CW'(PULSE_CYC - 1);
        end
        ST_PULSE: begin
          if (cnt == '0) st <= ST_HOLD;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign req_ready = ~busy;
  assign pulse     = (st == ST_PULSE);
endmodule

// File: rtl/disp_decoder.sv
module disp_decoder
  import disp_pkg::*;
#(
  parameter int CHARS = 64
) (
  input  logic [MOD_W-1:0]   mod_idx,
  input  logic               en_bank,
  input  logic               en_wr,
  output logic [MAX_MOD-1:0] sel_n
);
  localparam int NMOD = CHARS / (1 << DIG_W);

  for (genvar i = 0; i < MAX_MOD; i++) begin : g_out
    if (i < NMOD) begin : g_live
      assign sel_n[i] = ~(en_bank & en_wr & (mod_idx == MOD_W'(i)));
    end else begin : g_unused
      assign sel_n[i] = 1'b1;
    end
  end
endmodule

// File: rtl/disp_shadow.sv
module disp_shadow
  import disp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/disp_wr_if.sv
module disp_wr_if
  import disp_pkg::*;
#(
  parameter int CHARS     = 64,
  parameter int PULSE_CYC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [5:0]   req_addr,
  input  logic [6:0]   req_data,
  input  logic         bank_sel,
  output logic         busy,
  output logic [6:0]   disp_data,
  output logic [1:0]   disp_digit,
  output logic [15:0]  disp_wr_n,
  input  logic [5:0]   rd_addr,
  output logic [6:0]   rd_data
);
  logic              pulse;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  disp_seq #(.PULSE_CYC(PULSE_CYC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_ready (req_ready),
    .busy      (busy),
    .pulse     (pulse),
    .addr_q    (addr_q),
    .data_q    (data_q)
  );

  disp_decoder #(.CHARS(CHARS)) u_dec (
    .mod_idx (addr_q[ADDR_W-1:DIG_W]),
    .en_bank (bank_sel),
    .en_wr   (pulse),
    .sel_n   (disp_wr_n)
  );

  disp_shadow u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (~&disp_wr_n),
    .waddr (addr_q),
    .wdata (data_q),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign disp_data  = data_q;
  assign disp_digit = addr_q[DIG_W-1:0];
endmodule

// File: rtl/disp_wr_chk.sv
module disp_wr_chk #(
  parameter int CHARS = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [5:0]  req_addr,
  input logic        bank_sel,
  input logic        busy,
  input logic [6:0]  disp_data,
  input logic [1:0]  disp_digit,
  input logic [15:0] disp_wr_n
);
  logic [5:0] acc_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_addr <= '0;
    else if (req_valid && req_ready) acc_addr <= req_addr;
  end

  // R3: setup cycle after acceptance is busy with no strobe
  a_r3_setup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && &disp_wr_n));

  // R4: a strobe only falls after a setup cycle of the same sequence
  a_r4_strobe_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    !(&disp_wr_n) |-> (busy && $past(busy)));

  // R5: hold cycle follows the strobe
  a_r5_hold_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&disp_wr_n) |-> busy);

  // R5: bus stable throughout a sequence
  a_r5_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(disp_data) && $stable(disp_digit)));

  // R6: never two strobes at once
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~disp_wr_n));

  // R7: bank select gates every strobe
  a_r7_bank_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_sel |-> &disp_wr_n);

  // R8: out-of-range address never strobes
  a_r8_range_block: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int'(acc_addr) >= CHARS) |-> &disp_wr_n);
endmodule

bind disp_wr_if disp_wr_chk #(.CHARS(CHARS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .bank_sel   (bank_sel),
  .busy       (busy),
  .disp_data  (disp_data),
  .disp_digit (disp_digit),
  .disp_wr_n  (disp_wr_n)
);

// File: tb/sim_disp_wr_if.sv
`timescale 1ns/1ps
module sim_disp_wr_if;
  localparam int CHARS = 32;
  localparam int P     = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_addr = '0;
  logic [6:0]  req_data = '0;
  logic        bank_sel = 1'b1;
  logic        busy;
  logic [6:0]  disp_data;
  logic [1:0]  disp_digit;
  logic [15:0] disp_wr_n;
  logic [5:0]  rd_addr = '0;
  logic [6:0]  rd_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  disp_wr_if #(.CHARS(CHARS), .PULSE_CYC(P)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .bank_sel(bank_sel), .busy(busy),
    .disp_data(disp_data), .disp_digit(disp_digit), .disp_wr_n(disp_wr_n),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // behavioural reference
  int         m_cnt = 0;
  logic [5:0] m_addr = '0;
  logic [6:0] m_data = '0;
  logic [6:0] exp_sh [64];

  initial for (int i = 0; i < 64; i++) exp_sh[i] = '0;

  function automatic logic [15:0] exp_wr();
    logic [15:0] w = '1;
    if (m_cnt >= 2 && m_cnt <= P + 1 && bank_sel && int'(m_addr) < CHARS)
      w[m_addr[5:2]] = 1'b0;
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (exp_wr() != 16'hffff) exp_sh[m_addr] = m_data;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      else if (req_valid) begin
        m_cnt  = P + 2;
        m_addr = req_addr;
        m_data = req_data;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk("R2 busy", int'(busy), int'(m_cnt != 0));
      chk("R2 req_ready", int'(req_ready), int'(m_cnt == 0));
      chk("R4 R6 R7 R8 strobes", int'(disp_wr_n), int'(exp_wr()));
      chk("R3 R5 data bus", int'(disp_data), int'(m_data));
      chk("R3 R5 digit bus", int'(disp_digit), int'(m_addr[1:0]));
      chk("R9 R10 shadow read", int'(rd_data), int'(exp_sh[rd_addr]));
    end
  end

  task automatic send(input logic [5:0] a, input logic [6:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_data  = d;
    rd_addr   = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 busy", int'(busy), 0);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 strobes", int'(disp_wr_n), 16'hffff);
    chk("R1 data", int'(disp_data), 0);
    chk("R1 shadow", int'(rd_data), 0);
    // plain writes across modules and digits
    send(6'd5, 7'h41);
    send(6'd17, 7'h12);
    send(6'd31, 7'h7f);
    send(6'd0, 7'h01);
    // R8: beyond configured capacity
    send(6'd40, 7'h55);
    idle(P + 4);
    rd_addr = 6'd40;
    @(negedge clk); #2;
    chk("R8 no latch beyond range", int'(rd_data), 0);
    // R7: bank deselected for a whole write
    bank_sel = 1'b0;
    send(6'd9, 7'h33);
    idle(P + 3);
    bank_sel = 1'b1;
    @(negedge clk); #2;
    chk("R7 no latch when deselected", int'(rd_data), 0);
    // R2: request while busy is ignored
    send(6'd12, 7'h2a);
    req_valid = 1'b1; req_addr = 6'd13; req_data = 7'h66;
    @(negedge clk);
    req_valid = 1'b0;
    idle(P + 3);
    rd_addr = 6'd13;
    @(negedge clk); #2;
    chk("R2 busy request dropped", int'(rd_data), 0);
    // R7: bank select dropped in mid-pulse
    send(6'd20, 7'h44);
    idle(1);
    bank_sel = 1'b0;
    @(negedge clk);
    bank_sel = 1'b1;
    idle(P + 2);
    // back-to-back with valid held high
    @(negedge clk);
    req_valid = 1'b1; req_addr = 6'd2; req_data = 7'h10; rd_addr = 6'd2;
    idle(3 * (P + 3));
    req_addr = 6'd30; req_data = 7'h0f; rd_addr = 6'd30;
    idle(2 * (P + 3));
    req_valid = 1'b0;
    idle(P + 4);
    // sweep the read port
    for (int a = 0; a < 64; a++) begin
      rd_addr = 6'(a);
      @(negedge clk);
    end
    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule